// File: doc/BRIEF.md
# Byte-Lane Static Memory Core

This block is a clock-sampled functional model of a 32-bit-wide static memory with four independently maskable byte lanes. A word address picks one storage word. The data bus is split into a data-in vector, a data-out vector and one output-drive flag per byte lane, so a pad ring or a bus model can rebuild a tristate bus from them. Two select inputs of opposite polarity, an active-low write strobe, an active-low output gate and four active-low lane enables decide between four modes: deselected, standby, read and write.

All controls are sampled on the rising edge of `clk`. A write to a lane is the overlap of selection, the write strobe and that lane's enable. The overlap is remembered across clocks and committed to storage on the first clock where it has ended, using the address and data seen on the last overlapped clock. Reads are registered: outputs change one clock after the read controls are sampled. A read sampled on the clock that commits a write returns the new data. The depth is set by `ADDR_W`. The default of 8 keeps simulation small, and 19 gives the full 524,288-word array. Stored data carries no error correction.

Top module: `bytelane_sram`

## Requirements
- R1: While `rst` is high on a clock edge, every bit of `dq_oe` and `dout` is zero after that edge.
- R2: Lane i (`be_n[i]`, i = 0..3) owns data bits 8i+7 down to 8i in both writes and reads, and any combination of lanes may be enabled at once.
- R3: When `cs_n` is high or `ce` is low, the block is deselected. No lane is written, and all `dq_oe` bits are zero one clock after such a sample.
- R4: Lane i is in write overlap on a clock where `cs_n`=0, `ce`=1, `we_n`=0 and `be_n[i]`=0. The lane's storage is updated on the first clock where its overlap has ended, with the address and data sampled on the last overlapped clock. Addresses seen earlier in the same overlap are left untouched.
- R5: One clock after any sample with `we_n`=0, all `dq_oe` bits are zero, whatever `oe_n` is.
- R6: A read is sampled when `cs_n`=0, `ce`=1, `we_n`=1 and `oe_n`=0. One clock later, `dq_oe[i]` equals the inverse of the sampled `be_n[i]`, and each driven lane of `dout` carries that lane's stored byte at the sampled address.
- R7: A lane whose enable is high keeps its stored byte through a write. During a read its `dq_oe` bit is zero, and in every cycle a lane whose `dq_oe` bit is zero shows zero on `dout`.
- R8: With the block selected, `we_n`=1 and `oe_n`=1 (standby), all `dq_oe` bits are zero one clock later.
- R9: A read sampled on the clock that commits a write to the same address and lane returns the newly written byte.
- R10: Every address from 0 to 2^`ADDR_W`-1 is distinct storage, including the highest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset of the output and write-tracking state |
| addr | input | ADDR_W | Word address |
| din | input | 32 | Write data, four byte lanes |
| cs_n | input | 1 | Chip select, active low |
| ce | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| be_n | input | 4 | Lane enables, active low, bit i for data byte i |
| dout | output | 32 | Registered read data, zero in undriven lanes |
| dq_oe | output | 4 | Registered per-lane output drive flag |

## Verification
The bench goes after writes that finish in unusual ways. It ends one write by releasing a lane enable while the write strobe is still low; a design that commits only on the strobe's rising edge would lose that byte. It moves the address and the data mid-overlap; a design that writes every clock would corrupt the earlier address. It reads on the very clock a write commits; a design without a bypass would return stale contents. Masked-lane writes, deselect by either select input, standby, and a write strobe held low with the output gate low each check that protected bytes keep their value and that `dq_oe` stays clear where it must.

// File: rtl/bls_pkg.sv
package bls_pkg;

    // Operating mode decoded from the sampled control pins
    typedef enum logic [1:0] {
        MODE_DESEL   = 2'd0,
        MODE_STANDBY = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } mode_e;

    // Per-lane request bundle passed from the decoder to a lane
    typedef struct packed {
        logic wr;
        logic rd;
    } lane_req_t;

    // Selection wins over everything, then the write strobe, then the output gate
    function automatic mode_e decode_mode(
        input logic cs_n,
        input logic ce,
        input logic we_n,
        input logic oe_n
    );
        if (cs_n || !ce)
            return MODE_DESEL;
        else if (!we_n)
            return MODE_WRITE;
        else if (oe_n)
            return MODE_STANDBY;
        else
            return MODE_READ;
    endfunction

endpackage

// File: rtl/bls_decode.sv
module bls_decode
    import bls_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic              cs_n,
    input  logic              ce,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [NBYTES-1:0] be_n,
    output lane_req_t         req [NBYTES]
);

    mode_e mode;

    always_comb begin
        mode = decode_mode(cs_n, ce, we_n, oe_n);
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_req
        always_comb begin
            req[g].wr = (mode == MODE_WRITE) && !be_n[g];
            req[g].rd = (mode == MODE_READ)  && !be_n[g];
        end
    end

endmodule

// File: rtl/bls_lane.sv
module bls_lane
    import bls_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    input  lane_req_t         req,
    output logic [BYTE_W-1:0] q,
    output logic              q_en
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] store [DEPTH];

    // Tracking of an open write overlap on this lane
    logic              open_q;
    logic [ADDR_W-1:0] pend_addr;
    logic [BYTE_W-1:0] pend_data;
    logic              commit;
    logic              bypass;
    logic [BYTE_W-1:0] rd_byte;

    always_comb begin
        commit  = open_q && !req.wr;
        bypass  = commit && (pend_addr == addr);
        rd_byte = bypass ? pend_data : store[addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q    <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            open_q <= req.wr;
            if (req.wr) begin
                pend_addr <= addr;
                pend_data <= din;
            end
        end
    end

    // Storage is not reset: contents are undefined until written
    always_ff @(posedge clk) begin
        if (commit && !rst)
            store[pend_addr] <= pend_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q_en <= 1'b0;
        end else begin
            q_en <= req.rd;
            q    <= req.rd ? rd_byte : '0;
        end
    end

endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
    import bls_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*BYTE_W-1:0] din,
    input  logic                     cs_n,
    input  logic                     ce,
    input  logic                     we_n,
    input  logic                     oe_n,
    input  logic [NBYTES-1:0]        be_n,
    output logic [NBYTES*BYTE_W-1:0] dout,
    output logic [NBYTES-1:0]        dq_oe
);

    localparam int DATA_W = NBYTES * BYTE_W;

    lane_req_t         req [NBYTES];
    logic [DATA_W-1:0] lane_q;
    logic [NBYTES-1:0] lane_en;

    bls_decode #(
        .NBYTES (NBYTES)
    ) u_decode (
        .cs_n (cs_n),
        .ce   (ce),
        .we_n (we_n),
        .oe_n (oe_n),
        .be_n (be_n),
        .req  (req)
    );

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        bls_lane #(
            .ADDR_W (ADDR_W),
            .BYTE_W (BYTE_W)
        ) u_lane (
            .clk  (clk),
            .rst  (rst),
            .addr (addr),
            .din  (din[g*BYTE_W +: BYTE_W]),
            .req  (req[g]),
            .q    (lane_q[g*BYTE_W +: BYTE_W]),
            .q_en (lane_en[g])
        );
    end

    assign dout  = lane_q;
    assign dq_oe = lane_en;

endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cs_n,
    input logic                     ce,
    input logic                     we_n,
    input logic                     oe_n,
    input logic [NBYTES-1:0]        be_n,
    input logic [NBYTES*BYTE_W-1:0] dout,
    input logic [NBYTES-1:0]        dq_oe
);

    logic [NBYTES*BYTE_W-1:0] idle_mask;

    always_comb begin
        for (int i = 0; i < NBYTES; i++)
            idle_mask[i*BYTE_W +: BYTE_W] = {BYTE_W{!dq_oe[i]}};
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (dq_oe == '0 && dout == '0));

    // R3
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n || !ce) |=> (dq_oe == '0));

    // R5
    write_blocks_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> (dq_oe == '0));

    // R8
    standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && ce && we_n && oe_n) |=> (dq_oe == '0));

    // R6
    read_lane_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && ce && we_n && !oe_n) |=> (dq_oe == ~$past(be_n)));

    // R7
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((dout & idle_mask) == '0));

endmodule

bind bytelane_sram bls_checker #(
    .NBYTES (NBYTES),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n),
    .ce    (ce),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .be_n  (be_n),
    .dout  (dout),
    .dq_oe (dq_oe)
);

// File: tb/sim_bytelane_sram.sv
`timescale 1ns/1ps
module sim_bytelane_sram;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [31:0] din = '0;
    logic        cs_n = 1'b1;
    logic        ce = 1'b0;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [3:0]  be_n = 4'hF;
    logic [31:0] dout;
    logic [3:0]  dq_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bytelane_sram #(.ADDR_W(8), .NBYTES(4), .BYTE_W(8)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .din(din), .cs_n(cs_n), .ce(ce),
        .we_n(we_n), .oe_n(oe_n), .be_n(be_n), .dout(dout), .dq_oe(dq_oe)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;
        logic [3:0]  be;
        logic        oe;
        logic [31:0] exp_d;
        logic [3:0]  exp_oe;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h10, 32'hA1B2C3D4, 4'b0000, 1'b0, 32'h0,        4'h0},
        '{1'b0, 8'h10, 32'h0,        4'b0000, 1'b0, 32'hA1B2C3D4, 4'hF},
        '{1'b1, 8'h10, 32'h11223344, 4'b1010, 1'b0, 32'h0,        4'h0},
        '{1'b0, 8'h10, 32'h0,        4'b0000, 1'b0, 32'hA122C344, 4'hF},
        '{1'b0, 8'h10, 32'h0,        4'b0110, 1'b0, 32'hA1000044, 4'h9},
        '{1'b1, 8'h20, 32'hDEADBEEF, 4'b0000, 1'b0, 32'h0,        4'h0},
        '{1'b0, 8'h20, 32'h0,        4'b0000, 1'b1, 32'h0,        4'h0},
        '{1'b0, 8'h20, 32'h0,        4'b1111, 1'b0, 32'h0,        4'h0},
        '{1'b0, 8'h20, 32'h0,        4'b0000, 1'b0, 32'hDEADBEEF, 4'hF},
        '{1'b1, 8'hFF, 32'h5A5A5A5A, 4'b0000, 1'b0, 32'h0,        4'h0},
        '{1'b0, 8'hFF, 32'h0,        4'b0000, 1'b0, 32'h5A5A5A5A, 4'hF},
        '{1'b0, 8'h10, 32'h0,        4'b1100, 1'b0, 32'h0000C344, 4'h3}
    };

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1'b0; ce = 1'b1; we_n = 1'b1; oe_n = 1'b1; be_n = 4'hF;
    endtask

    // Two-clock write; output gate held low to show the strobe masks it (R5)
    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        addr = a; din = d; cs_n = 1'b0; ce = 1'b1; we_n = 1'b0; oe_n = 1'b0; be_n = be;
        @(negedge clk);
        check("R5 no drive during write", {28'h0, dq_oe}, 32'h0);
        idle();
        @(posedge clk);
    endtask

    task automatic do_read(input logic [7:0] a, input logic [3:0] be, input logic oe,
                           input logic [31:0] exp_d, input logic [3:0] exp_oe, input string req);
        @(negedge clk);
        addr = a; cs_n = 1'b0; ce = 1'b1; we_n = 1'b1; oe_n = oe; be_n = be;
        @(negedge clk);
        check(req, dout, exp_d);
        check(req, {28'h0, dq_oe}, {28'h0, exp_oe});
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset dout", dout, 32'h0);
        check("R1 reset dq_oe", {28'h0, dq_oe}, 32'h0);
        rst = 1'b0;
        idle();

        // Table walk: R2 lane mapping, R6 read, R7 masked lanes, R8 standby, R10 top address
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr)
                do_write(VECS[i].a, VECS[i].d, VECS[i].be);
            else
                do_read(VECS[i].a, VECS[i].be, VECS[i].oe, VECS[i].exp_d, VECS[i].exp_oe,
                        "R2 R6 R7 R8 R10 table read");
        end

        // R3: write attempt with chip select high, then with chip enable low
        @(negedge clk);
        addr = 8'h10; din = 32'h0; cs_n = 1'b1; ce = 1'b1; we_n = 1'b0; oe_n = 1'b0; be_n = 4'h0;
        @(negedge clk);
        check("R3 deselect by cs_n", {28'h0, dq_oe}, 32'h0);
        cs_n = 1'b0; ce = 1'b0;
        @(negedge clk);
        check("R3 deselect by ce", {28'h0, dq_oe}, 32'h0);
        idle();
        do_read(8'h10, 4'h0, 1'b0, 32'hA122C344, 4'hF, "R3 deselected write ignored");

        // R4: address and data move during one overlap; only the last pair lands
        do_write(8'h30, 32'h01010101, 4'h0);
        @(negedge clk);
        addr = 8'h30; din = 32'hEEEEEEEE; we_n = 1'b0; oe_n = 1'b1; be_n = 4'h0;
        @(negedge clk);
        addr = 8'h31; din = 32'h77777777;
        @(negedge clk);
        din = 32'h12345678;
        @(negedge clk);
        idle();
        do_read(8'h30, 4'h0, 1'b0, 32'h01010101, 4'hF, "R4 earlier overlap address untouched");
        do_read(8'h31, 4'h0, 1'b0, 32'h12345678, 4'hF, "R4 last overlap data committed");

        // R4 R2: overlap ended by lane enable release while strobe stays low
        @(negedge clk);
        addr = 8'h20; din = 32'h000000AA; we_n = 1'b0; be_n = 4'b1110;
        @(negedge clk);
        be_n = 4'hF;
        @(negedge clk);
        idle();
        do_read(8'h20, 4'h0, 1'b0, 32'hDEADBEAA, 4'hF, "R4 lane-enable ended write");

        // R9: read sampled on the commit clock returns new data
        @(negedge clk);
        addr = 8'h40; din = 32'hCAFEF00D; we_n = 1'b0; oe_n = 1'b0; be_n = 4'h0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        check("R9 read on commit clock", dout, 32'hCAFEF00D);
        idle();

        // R1: reset in the middle of a read
        @(negedge clk);
        addr = 8'h40; we_n = 1'b1; oe_n = 1'b0; be_n = 4'h0; rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset dq_oe", {28'h0, dq_oe}, 32'h0);
        check("R1 mid-run reset dout", dout, 32'h0);
        rst = 1'b0;
        idle();
        do_read(8'h40, 4'b0101, 1'b0, 32'hCA00F000, 4'hA, "R7 storage survives reset");

        summary();
        $finish;
    end

endmodule